// File: doc/BRIEF.md
# Masked Receive Control Character Matcher

This block sits behind a serial receiver and classifies every received character against a small programmable table of control characters. A shared bit mask selects which bit positions take part in each comparison. The table is scanned from its lowest index upward and stops at the first entry marked as the end of the table. The first entry that matches decides what happens to the character.

When the matching entry carries its reject flag, the character is kept out of the receive buffer. It is placed instead in a single control character register, and a maskable interrupt is raised. If software has not read that register before the next rejected character arrives, the old value is replaced and an overrun indication is set. When the matching entry has no reject flag, the character goes to the buffer as usual, tagged as a control character. The decision is registered and appears one clock after the receive strobe. The buffer write path can therefore be gated by it directly.

Top module: `rcc_matcher`

## Requirements
- R1: After reset the table is empty (every slot holds the end code), the mask is all ones, `ctrl_char` is zero and `dec_valid`, `ctrl_pending`, `ctrl_overrun` and `irq` are low. With an empty table every character is stored with `dec_ctrl_flag` low.
- R2: A table entry is 11 bits: bits [10:9] are the flag code, bit 8 is the reject flag and bits [7:0] are the character. The mask written through `cfg_mask` compares bit k only when mask bit k is 1. Masked-out bits never prevent a match.
- R3: Scanning stops at the lowest index whose flag code is 2'b11. That entry and every entry above it never match. A table with no such entry is scanned through all eight slots.
- R4: When several live entries match, the lowest index decides the action.
- R5: A match on an entry with reject flag 1 gives `dec_store`=0 and `dec_ctrl_flag`=0. The character is loaded into `ctrl_char` and `ctrl_pending` is set.
- R6: A match on an entry with reject flag 0 gives `dec_store`=1 and `dec_ctrl_flag`=1.
- R7: A character that matches no live entry gives `dec_store`=1 and `dec_ctrl_flag`=0.
- R8: `dec_valid`, `dec_store`, `dec_ctrl_flag` and `dec_char` are updated exactly one clock after a cycle with `rx_valid` high. `dec_valid` is low after any cycle with `rx_valid` low.
- R9: A rejected capture while `ctrl_pending` is high and `ctrl_rd` is low overwrites `ctrl_char` and sets `ctrl_overrun`.
- R10: A cycle with `ctrl_rd` high and no capture clears `ctrl_pending` and `ctrl_overrun` on the next clock.
- R11: `irq` equals `ctrl_pending` AND `irq_en`.
- R12: A capture in the same cycle as `ctrl_rd` leaves `ctrl_pending` high with the new character and `ctrl_overrun` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_tbl_we | input | 1 | Write strobe for one table slot |
| cfg_idx | input | 3 | Table slot to write |
| cfg_entry | input | 11 | Entry word: flag code [10:9], reject [8], character [7:0] |
| cfg_mask_we | input | 1 | Write strobe for the comparison mask |
| cfg_mask | input | 8 | Comparison mask, 1 = bit compared |
| irq_en | input | 1 | Interrupt enable |
| rx_valid | input | 1 | Received character strobe |
| rx_char | input | 8 | Received character |
| ctrl_rd | input | 1 | Software read acknowledge of the control register |
| dec_valid | output | 1 | Decision valid, one clock after the strobe |
| dec_store | output | 1 | Character is to be written to the receive buffer |
| dec_ctrl_flag | output | 1 | Stored character matched a non-rejecting entry |
| dec_char | output | 8 | Character the decision refers to |
| ctrl_char | output | 8 | Last rejected control character |
| ctrl_pending | output | 1 | Control register holds an unread character |
| ctrl_overrun | output | 1 | An unread control character was overwritten |
| irq | output | 1 | Maskable control character interrupt |

## Verification
The case that is hardest to reach is a capture that lands on a pending register in the same cycle as the software read. Two outcomes must be kept apart there: an overwrite with overrun, and a clean hand-over. The stimulus sweeps all 256 character values back to back through tables that hold several rejecting entries. The read strobe follows a bit of the character value, so captures land on a register that was read, unread or being read in that very cycle. A second table has no end code and shadows entries under a partial mask. This exercises full-depth scans and lowest-index priority.

// File: rtl/rcc_pkg.sv
package rcc_pkg;
  localparam int FLAG_W = 2;
  localparam logic [FLAG_W-1:0] END_CODE = 2'b11;
endpackage

// File: rtl/rcc_table.sv
module rcc_table #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 8,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int ENT_W = DATA_W + 1 + rcc_pkg::FLAG_W
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          tbl_we,
  input  logic [IDX_W-1:0]              tbl_idx,
  input  logic [ENT_W-1:0]              tbl_wdata,
  input  logic                          mask_we,
  input  logic [DATA_W-1:0]             mask_wdata,
  output logic [DEPTH-1:0][ENT_W-1:0]   entries,
  output logic [DATA_W-1:0]             mask
);
  localparam logic [ENT_W-1:0] EMPTY = {rcc_pkg::END_CODE, {(ENT_W-rcc_pkg::FLAG_W){1'b0}}};

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    always_ff @(posedge clk) begin
      if (rst)
        entries[i] <= EMPTY;
      else if (tbl_we && tbl_idx == IDX_W'(i))
        entries[i] <= tbl_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)          mask <= '1;
    else if (mask_we) mask <= mask_wdata;
  end
endmodule

// File: rtl/rcc_compare.sv
module rcc_compare #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 8,
  localparam int ENT_W = DATA_W + 1 + rcc_pkg::FLAG_W
) (
  input  logic [DATA_W-1:0]           rx_char,
  input  logic [DEPTH-1:0][ENT_W-1:0] entries,
  input  logic [DATA_W-1:0]           mask,
  output logic                        hit,
  output logic                        hit_reject
);
  logic [DEPTH-1:0] live;
  logic [DEPTH-1:0] match;

  for (genvar i = 0; i < DEPTH; i++) begin : g_cmp
    logic term;
    assign term = entries[i][ENT_W-1 -: rcc_pkg::FLAG_W] == rcc_pkg::END_CODE;
    if (i == 0) begin : g_first
      assign live[i] = !term;
    end else begin : g_rest
      assign live[i] = live[i-1] && !term;
    end
    assign match[i] = live[i] && (((rx_char ^ entries[i][DATA_W-1:0]) & mask) == '0);
  end

  // Lowest index wins: scan from the top so the lowest match is applied last.
  always_comb begin
    hit        = 1'b0;
    hit_reject = 1'b0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (match[i]) begin
        hit        = 1'b1;
        hit_reject = entries[i][DATA_W];
      end
    end
  end
endmodule

// File: rtl/rcc_capture.sv
module rcc_capture #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cap_en,
  input  logic [DATA_W-1:0] cap_char,
  input  logic              rd,
  output logic [DATA_W-1:0] held_char,
  output logic              pending,
  output logic              overrun
);
  always_ff @(posedge clk) begin
    if (rst) begin
      held_char <= '0;
      pending   <= 1'b0;
      overrun   <= 1'b0;
    end else begin
      if (cap_en) held_char <= cap_char;
      pending <= cap_en || (pending && !rd);
      overrun <= (cap_en && pending && !rd) || (overrun && !rd);
    end
  end

  // R5
  capture_load_chk: assert property (@(posedge clk) disable iff (rst)
    cap_en |=> pending && held_char == $past(cap_char));
  // R9
  overwrite_overrun_chk: assert property (@(posedge clk) disable iff (rst)
    (cap_en && pending && !rd) |=> overrun);
  // R10
  read_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (rd && !cap_en) |=> !pending && !overrun);
  // R12
  read_with_capture_chk: assert property (@(posedge clk) disable iff (rst)
    (rd && cap_en) |=> pending && !overrun);
endmodule

// File: rtl/rcc_matcher.sv
module rcc_matcher #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 8,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int ENT_W = DATA_W + 1 + rcc_pkg::FLAG_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_tbl_we,
  input  logic [IDX_W-1:0]  cfg_idx,
  input  logic [ENT_W-1:0]  cfg_entry,
  input  logic              cfg_mask_we,
  input  logic [DATA_W-1:0] cfg_mask,
  input  logic              irq_en,
  input  logic              rx_valid,
  input  logic [DATA_W-1:0] rx_char,
  input  logic              ctrl_rd,
  output logic              dec_valid,
  output logic              dec_store,
  output logic              dec_ctrl_flag,
  output logic [DATA_W-1:0] dec_char,
  output logic [DATA_W-1:0] ctrl_char,
  output logic              ctrl_pending,
  output logic              ctrl_overrun,
  output logic              irq
);
  logic [DEPTH-1:0][ENT_W-1:0] entries;
  logic [DATA_W-1:0]           mask;
  logic                        hit, hit_reject, cap_en;

  rcc_table #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_table (
    .clk(clk), .rst(rst), .tbl_we(cfg_tbl_we), .tbl_idx(cfg_idx),
    .tbl_wdata(cfg_entry), .mask_we(cfg_mask_we), .mask_wdata(cfg_mask),
    .entries(entries), .mask(mask)
  );

  rcc_compare #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_cmp (
    .rx_char(rx_char), .entries(entries), .mask(mask),
    .hit(hit), .hit_reject(hit_reject)
  );

  assign cap_en = rx_valid && hit && hit_reject;

  rcc_capture #(.DATA_W(DATA_W)) u_cap (
    .clk(clk), .rst(rst), .cap_en(cap_en), .cap_char(rx_char), .rd(ctrl_rd),
    .held_char(ctrl_char), .pending(ctrl_pending), .overrun(ctrl_overrun)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      dec_valid     <= 1'b0;
      dec_store     <= 1'b0;
      dec_ctrl_flag <= 1'b0;
      dec_char      <= '0;
    end else begin
      dec_valid <= rx_valid;
      if (rx_valid) begin
        dec_store     <= !(hit && hit_reject);
        dec_ctrl_flag <= hit && !hit_reject;
        dec_char      <= rx_char;
      end
    end
  end

  assign irq = ctrl_pending && irq_en;

  // R8
  strobe_to_decision_chk: assert property (@(posedge clk) disable iff (rst)
    rx_valid |=> dec_valid && dec_char == $past(rx_char));
  // R8
  idle_no_decision_chk: assert property (@(posedge clk) disable iff (rst)
    !rx_valid |=> !dec_valid);
  // R5
  reject_not_flagged_chk: assert property (@(posedge clk) disable iff (rst)
    (dec_valid && !dec_store) |-> !dec_ctrl_flag);
  // R5
  reject_loads_register_chk: assert property (@(posedge clk) disable iff (rst)
    (dec_valid && !dec_store) |-> ctrl_pending && ctrl_char == dec_char);
  // R11
  irq_needs_pending_chk: assert property (@(posedge clk) disable iff (rst)
    irq |-> ctrl_pending);
endmodule

// File: tb/rcc_matcher_test.sv
module rcc_matcher_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_tbl_we = 0, cfg_mask_we = 0, irq_en = 0, rx_valid = 0, ctrl_rd = 0;
  logic [2:0]  cfg_idx = '0;
  logic [10:0] cfg_entry = '0;
  logic [7:0]  cfg_mask = '0, rx_char = '0;
  logic dec_valid, dec_store, dec_ctrl_flag, ctrl_pending, ctrl_overrun, irq;
  logic [7:0] dec_char, ctrl_char;

  int checks = 0, fails = 0;
  logic [1:0] m_flag [8];
  logic       m_rej  [8];
  logic [7:0] m_ch   [8];
  logic [7:0] m_mask = 8'hFF, m_held = 8'h00;
  logic       m_pend = 0, m_ovr = 0;

  always #10 clk = ~clk;

  rcc_matcher uut (
    .clk(clk), .rst(rst), .cfg_tbl_we(cfg_tbl_we), .cfg_idx(cfg_idx),
    .cfg_entry(cfg_entry), .cfg_mask_we(cfg_mask_we), .cfg_mask(cfg_mask),
    .irq_en(irq_en), .rx_valid(rx_valid), .rx_char(rx_char), .ctrl_rd(ctrl_rd),
    .dec_valid(dec_valid), .dec_store(dec_store), .dec_ctrl_flag(dec_ctrl_flag),
    .dec_char(dec_char), .ctrl_char(ctrl_char), .ctrl_pending(ctrl_pending),
    .ctrl_overrun(ctrl_overrun), .irq(irq)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
  end

  task automatic prog(input int idx, input logic [1:0] fl, input logic rj, input logic [7:0] ch);
    @(negedge clk);
    cfg_tbl_we = 1; cfg_idx = 3'(idx); cfg_entry = {fl, rj, ch};
    m_flag[idx] = fl; m_rej[idx] = rj; m_ch[idx] = ch;
    @(negedge clk);
    cfg_tbl_we = 0;
  endtask

  task automatic set_mask(input logic [7:0] m);
    @(negedge clk);
    cfg_mask_we = 1; cfg_mask = m; m_mask = m;
    @(negedge clk);
    cfg_mask_we = 0;
  endtask

  // Returns 0 no match, 1 stored-flagged, 2 rejected (R3, R4 scan model)
  function automatic int classify(input logic [7:0] c);
    for (int i = 0; i < 8; i++) begin
      if (m_flag[i] == 2'b11) return 0;
      if (((c ^ m_ch[i]) & m_mask) == 8'h00) return m_rej[i] ? 2 : 1;
    end
    return 0;
  endfunction

  // Sweep every character; rd_sel picks which character bit drives the read strobe
  task automatic sweep(input logic en, input int rd_sel);
    irq_en = en;
    @(negedge clk);
    for (int c = 0; c < 256; c++) begin
      logic [7:0] cv;
      logic rd, cap;
      int k;
      cv = 8'(c);
      rd = cv[rd_sel];
      rx_valid = 1; rx_char = cv; ctrl_rd = rd;
      k = classify(cv);
      cap = (k == 2);
      m_ovr  = (cap && m_pend && !rd) || (m_ovr && !rd);
      m_pend = cap || (m_pend && !rd);
      if (cap) m_held = cv;
      @(negedge clk);
      chk("R8 valid", int'(dec_valid), 1);
      chk("R8 char", int'(dec_char), c);
      if (k == 2) begin
        chk("R5 store", int'(dec_store), 0);
        chk("R5 flag", int'(dec_ctrl_flag), 0);
      end else if (k == 1) begin
        chk("R6 store", int'(dec_store), 1);
        chk("R6 flag", int'(dec_ctrl_flag), 1);
      end else begin
        chk("R7 store", int'(dec_store), 1);
        chk("R7 flag", int'(dec_ctrl_flag), 0);
      end
      chk("R9 held", int'(ctrl_char), int'(m_held));
      chk("R10 pending", int'(ctrl_pending), int'(m_pend));
      chk("R12 overrun", int'(ctrl_overrun), int'(m_ovr));
      chk("R11 irq", int'(irq), int'(m_pend && en));
    end
    rx_valid = 0; ctrl_rd = 0;
    @(negedge clk);
    chk("R8 idle", int'(dec_valid), 0);
  endtask

  initial begin
    for (int i = 0; i < 8; i++) begin
      m_flag[i] = 2'b11; m_rej[i] = 0; m_ch[i] = 0;
    end
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 0;
    // R1 reset state
    chk("R1 valid", int'(dec_valid), 0);
    chk("R1 pending", int'(ctrl_pending), 0);
    chk("R1 overrun", int'(ctrl_overrun), 0);
    chk("R1 ctrl_char", int'(ctrl_char), 0);
    chk("R1 irq", int'(irq), 0);
    // R1 empty table: everything stored, nothing flagged
    sweep(1'b1, 0);

    // Table A, full mask: reject 11/13, non-reject 41, shadowed 41 reject, end at 4, dead 55 (R3, R4)
    prog(0, 2'b00, 1, 8'h11);
    prog(1, 2'b01, 1, 8'h13);
    prog(2, 2'b10, 0, 8'h41);
    prog(3, 2'b00, 1, 8'h41);
    prog(4, 2'b11, 0, 8'h00);
    prog(5, 2'b00, 1, 8'h55);
    sweep(1'b1, 0);
    sweep(1'b0, 2);

    // Table B, upper nibble mask, no end code (R2, R3, R4)
    set_mask(8'hF0);
    prog(0, 2'b00, 1, 8'h30);
    prog(1, 2'b00, 0, 8'hA5);
    prog(2, 2'b00, 0, 8'h3F);
    prog(3, 2'b00, 1, 8'h70);
    prog(4, 2'b00, 0, 8'h71);
    prog(5, 2'b00, 1, 8'hC0);
    prog(6, 2'b00, 0, 8'hD0);
    prog(7, 2'b10, 1, 8'hE9);
    sweep(1'b1, 1);
    sweep(1'b1, 4);
    report();
  end
endmodule